// File: doc/BRIEF.md
# Scanning Minimum / Maximum / Mean Engine

This block keeps a small bank of sample words that a host fills one word per clock through a synchronous write port. When the host pulses a start request, a controller walks every entry of the bank in ascending order, one per cycle, while a datapath accumulates a running total and keeps the smallest and largest word seen. Once the walk ends, the mean is formed by shifting the total right by the address width, and a completion flag is raised.

The host then picks one of the three results through a two-bit result selector. The flag stays set until the host requests a new run. While a run is in progress, the bank is locked against writes and further start requests are ignored. The bank depth is a power of two, so the division needs no divider.

Top module: `mmav_scan_unit`

## Requirements
- R1: After reset the completion flag is 0 and the result bus reads 0 for every selector value; all bank words read as 0.
- R2: With no run in progress, a word presented with the write enable high is stored at the given address on the next rising clock edge.
- R3: A start request sampled while idle is accepted: the completion flag reads 0 after that edge and rises exactly DEPTH+1 clock edges after the accepting edge.
- R4: The minimum result equals the smallest bank word. A word replaces the running minimum only when it is strictly smaller, so a bank of equal words yields that word.
- R5: The maximum result equals the largest bank word. A word replaces the running maximum only when it is strictly larger, so a bank of equal words yields that word.
- R6: The mean result equals floor(sum of all words / DEPTH). The total is DATA_W+log2(DEPTH) bits wide, so a bank of all-ones words gives an all-ones mean.
- R7: The result selector encodes 2'b01 = minimum, 2'b10 = maximum, 2'b11 = mean and 2'b00 = zero on the bus.
- R8: Once set, the completion flag stays 1 until the next accepted start request.
- R9: Writes that arrive while a run is in progress do not change the bank, which is visible in the results of that run and of the next run.
- R10: A start request during a run is ignored: the completion flag still rises DEPTH+1 edges after the original accepting edge.
- R11: Each run reloads the running minimum with all ones, the maximum with 0 and the total with 0, so the results reflect only the bank contents at that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| wr_en_i | input | 1 | Write enable for the sample bank |
| wr_addr_i | input | log2(DEPTH) | Bank address for the write |
| wr_data_i | input | DATA_W | Word to store |
| go_i | input | 1 | Start request for a run |
| res_sel_i | input | 2 | Result selector |
| res_data_o | output | DATA_W | Selected result |
| done_o | output | 1 | Completion flag |

## Verification
The accepting edge of a start request clears the completion flag at once, and the flag rises DEPTH+1 edges later: DEPTH edges of accumulation and one edge to latch the mean. The bench counts rising edges from the accepting edge, samples the flag on the falling edge after each one, and requires the first high sample at exactly edge DEPTH+1. Results are read only after the flag is high. The bus is combinational from the selector, so the scoreboard drives the selector on a falling edge and compares a quarter period later.

// File: rtl/mmav_pkg.sv
package mmav_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } mmav_state_e;

    localparam logic [1:0] SEL_ZERO = 2'b00;
    localparam logic [1:0] SEL_MIN  = 2'b01;
    localparam logic [1:0] SEL_MAX  = 2'b10;
    localparam logic [1:0] SEL_MEAN = 2'b11;

endpackage

// File: rtl/mmav_store.sv
module mmav_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              lock_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    // one row per entry, each with its own write decode
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en_i && !lock_i && (wr_addr_i == ADDR_W'(g))) begin
                mem_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/mmav_ctrl.sv
module mmav_ctrl
    import mmav_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              go_i,
    output logic              busy_o,
    output logic              scan_o,
    output logic              init_o,
    output logic              fin_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic              done_o
);

    typedef struct packed {
        mmav_state_e       state;
        logic [ADDR_W-1:0] idx;
        logic              done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        init_o = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (go_i) begin
                    init_o     = 1'b1;
                    st_d.state = ST_SCAN;
                    st_d.idx   = '0;
                    st_d.done  = 1'b0;
                end
            end
            ST_SCAN: begin
                st_d.idx = st_q.idx + 1'b1;
                if (st_q.idx == ADDR_W'(DEPTH - 1)) begin
                    st_d.state = ST_FINISH;
                end
            end
            ST_FINISH: begin
                st_d.state = ST_IDLE;
                st_d.done  = 1'b1;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '{state: ST_IDLE, idx: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.state != ST_IDLE);
    assign scan_o = (st_q.state == ST_SCAN);
    assign fin_o  = (st_q.state == ST_FINISH);
    assign idx_o  = st_q.idx;
    assign done_o = st_q.done;

endmodule

// File: rtl/mmav_acc.sv
module mmav_acc #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int SUM_W  = DATA_W + ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              init_i,
    input  logic              en_i,
    input  logic              fin_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] min_o,
    output logic [DATA_W-1:0] max_o,
    output logic [DATA_W-1:0] mean_o
);

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic [SUM_W-1:0]  sum;
        logic [DATA_W-1:0] mean;
    } acc_t;

    acc_t ac_d, ac_q;

    always_comb begin
        ac_d = ac_q;
        if (init_i) begin
            ac_d.lo  = '1;
            ac_d.hi  = '0;
            ac_d.sum = '0;
        end else if (en_i) begin
            ac_d.sum = ac_q.sum + SUM_W'(word_i);
            if (word_i < ac_q.lo) ac_d.lo = word_i;
            if (word_i > ac_q.hi) ac_d.hi = word_i;
        end
        if (fin_i) begin
            ac_d.mean = DATA_W'(ac_q.sum >> ADDR_W);
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            ac_q <= '0;
        end else begin
            ac_q <= ac_d;
        end
    end

    assign min_o  = ac_q.lo;
    assign max_o  = ac_q.hi;
    assign mean_o = ac_q.mean;

endmodule

// File: rtl/mmav_scan_unit.sv
module mmav_scan_unit
    import mmav_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              go_i,
    input  logic [1:0]        res_sel_i,
    output logic [DATA_W-1:0] res_data_o,
    output logic              done_o
);

    logic              busy, scan_phase, acc_init, acc_fin;
    logic [ADDR_W-1:0] scan_idx;
    logic [DATA_W-1:0] scan_word, min_val, max_val, mean_val;

    mmav_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .go_i   (go_i),
        .busy_o (busy),
        .scan_o (scan_phase),
        .init_o (acc_init),
        .fin_o  (acc_fin),
        .idx_o  (scan_idx),
        .done_o (done_o)
    );

    mmav_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .lock_i    (busy),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (scan_idx),
        .rd_data_o (scan_word)
    );

    mmav_acc #(.DATA_W(DATA_W), .DEPTH(DEPTH)) acc_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .init_i (acc_init),
        .en_i   (scan_phase),
        .fin_i  (acc_fin),
        .word_i (scan_word),
        .min_o  (min_val),
        .max_o  (max_val),
        .mean_o (mean_val)
    );

    always_comb begin
        unique case (res_sel_i)
            SEL_MIN:  res_data_o = min_val;
            SEL_MAX:  res_data_o = max_val;
            SEL_MEAN: res_data_o = mean_val;
            default:  res_data_o = '0;
        endcase
    end

endmodule

// File: rtl/mmav_scan_chk.sv
module mmav_scan_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              go_i,
    input logic              busy,
    input logic              scan_phase,
    input logic              done_o,
    input logic [1:0]        res_sel_i,
    input logic [DATA_W-1:0] res_data_o,
    input logic [DATA_W-1:0] min_val,
    input logic [DATA_W-1:0] max_val,
    input logic [DATA_W-1:0] mean_val
);

    // R3
    go_clears_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (go_i && !busy) |=> !done_o);

    // R8
    done_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !go_i) |=> done_o);

    // R10
    no_early_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        scan_phase |=> !done_o);

    // R4
    min_le_max_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (min_val <= max_val));

    // R6
    mean_bounded_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (mean_val >= min_val && mean_val <= max_val));

    // R7
    zero_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_sel_i == 2'b00) |-> (res_data_o == '0));

endmodule

bind mmav_scan_unit mmav_scan_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .go_i       (go_i),
    .busy       (busy),
    .scan_phase (scan_phase),
    .done_o     (done_o),
    .res_sel_i  (res_sel_i),
    .res_data_o (res_data_o),
    .min_val    (min_val),
    .max_val    (max_val),
    .mean_val   (mean_val)
);

// File: tb/mmav_scan_unit_tb.sv
module mmav_scan_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 32;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              go = 1'b0;
    logic [1:0]        res_sel = 2'b00;
    logic [DATA_W-1:0] res_data;
    logic              done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] model [DEPTH];

    logic [1:0]        sel_q [$];
    logic [DATA_W-1:0] exp_q [$];
    string             req_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mmav_scan_unit #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .go_i       (go),
        .res_sel_i  (res_sel),
        .res_data_o (res_data),
        .done_o     (done)
    );

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_item(logic [1:0] s, logic [DATA_W-1:0] v, string req);
        sel_q.push_back(s);
        exp_q.push_back(v);
        req_q.push_back(req);
    endtask

    // monitor: drive selector on falling edge, compare a quarter period later
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                res_sel = sel_q[0];
                #(CLK_PERIOD/4);
                check(req_q[0], int'(res_data), int'(exp_q[0]));
                void'(sel_q.pop_front());
                void'(exp_q.pop_front());
                void'(req_q.pop_front());
            end
        end
    end

    task automatic write_word(int a, logic [DATA_W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        model[a] = v;
    endtask

    task automatic push_results(string tag);
        int lo = (1 << DATA_W) - 1;
        int hi = 0;
        int sum = 0;
        for (int i = 0; i < DEPTH; i++) begin
            sum += int'(model[i]);
            if (int'(model[i]) < lo) lo = int'(model[i]);
            if (int'(model[i]) > hi) hi = int'(model[i]);
        end
        expect_item(2'b01, DATA_W'(lo), {"R4 R7 min ", tag});
        expect_item(2'b10, DATA_W'(hi), {"R5 R7 max ", tag});
        expect_item(2'b11, DATA_W'(sum / DEPTH), {"R6 R7 mean ", tag});
        expect_item(2'b00, '0, {"R7 zero ", tag});
        wait (exp_q.size() == 0);
    endtask

    // run one scan; disturb = write and start request mid-run (R9, R10)
    task automatic run_scan(bit disturb, string tag);
        int cyc = 0;
        @(negedge clk);
        go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
        check("R3 done cleared", int'(done), 0);
        while (cyc < 200) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            wr_en = 1'b0;
            go = 1'b0;
            if (done) break;
            if (disturb && cyc == 10) begin
                wr_en = 1'b1; wr_addr = '0; wr_data = ~model[0]; go = 1'b1;
            end
        end
        if (disturb) check("R10 done edge count", cyc, DEPTH + 1);
        else         check("R3 done edge count", cyc, DEPTH + 1);
        push_results(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 done after reset", int'(done), 0);
        expect_item(2'b00, '0, "R1 sel00");
        expect_item(2'b01, '0, "R1 sel01");
        expect_item(2'b10, '0, "R1 sel10");
        expect_item(2'b11, '0, "R1 sel11");
        wait (exp_q.size() == 0);
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        // R1: bank reset to zero
        run_scan(1'b0, "R1 reset bank");

        // R2: ramp pattern stored through write port
        for (int i = 0; i < DEPTH; i++) write_word(i, DATA_W'((i * 37 + 11) % 251));
        run_scan(1'b0, "R2 ramp");

        // R8: done held while idle
        repeat (5) @(negedge clk);
        check("R8 done held", int'(done), 1);

        // R4 R5: equal words
        for (int i = 0; i < DEPTH; i++) write_word(i, 8'h55);
        run_scan(1'b0, "R4 R5 equal");

        // R6 R11: all ones
        for (int i = 0; i < DEPTH; i++) write_word(i, 8'hFF);
        run_scan(1'b0, "R6 R11 ones");

        // R11: zeros after all ones, one spike
        for (int i = 0; i < DEPTH; i++) write_word(i, (i == 17) ? 8'h40 : 8'h00);
        run_scan(1'b0, "R11 spike");

        // R9 R10: disturbed run, model keeps old word 0
        write_word(0, 8'h21);
        for (int i = 1; i < DEPTH; i++) write_word(i, DATA_W'(200 - i * 3));
        run_scan(1'b1, "R9 R10 disturbed");
        run_scan(1'b0, "R9 after disturb");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule